// File: doc/BRIEF.md
# Reset and Low-Power Mode Controller

This controller decides when the core may run. It merges three reset causes into one core reset: the power-on indication, an active-low external reset pin and a watchdog time-out pulse. It also carries the core into and out of a halted low-power state. Every reset release and every wake-up is followed by a fixed start-up wait of 1024 oscillator cycles, so the oscillator can settle before the system clock is enabled again. The oscillator clock itself keeps running throughout.

Two status flags record how the chip last woke or was reset. These are the time-out flag (TO) and the power-down flag (PD). Each reset source updates them by its own rule, and the rule depends on whether the core was running or halted at the time. Software reads the flags after a reset to tell apart power-on, an external reset and a watchdog reset, each taken either while running or while halted.

A wake-up caused by an interrupt raises a one-cycle service request. This request comes one cycle after the system clock is enabled again. A plain wake-up lets the next instruction run as soon as the clock returns.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, `core_rst`=1, `ready`=0, `sys_clk_en`=0, `irq_svc`=0, `flag_to`=0 and `flag_pd`=0.
- R2: Any reset (power-on, external, watchdog) holds `core_rst`=1 and `ready`=0 until the start-up wait ends. The external pin passes through a two-flop synchroniser, so it takes effect at the third rising edge after it goes low. The reset is held for as long as the pin stays low.
- R3: After a reset is released, or a wake-up is accepted, `sys_clk_en` and `ready` stay 0 for exactly 1024 clock cycles. They rise together with `core_rst` falling, or after a wake-up with `core_rst` staying 0.
- R4: A reset that arrives during the start-up wait restarts the 1024-cycle count from zero.
- R5: A `halt_req` while running drops `sys_clk_en` in the next cycle, sets `flag_pd`=1 and clears `flag_to`=0. While halted, `ready`=1 and `core_rst`=0. A `halt_req` during the start-up wait is ignored.
- R6: An external reset while running leaves `flag_to` and `flag_pd` unchanged. An external reset while halted sets `flag_to`=0 and `flag_pd`=1.
- R7: A watchdog time-out while running sets `flag_to`=1 and leaves `flag_pd` unchanged. A watchdog time-out while halted sets `flag_to`=1 and `flag_pd`=1.
- R8: While halted, `wake_evt` or `irq_wake` starts the wait. After `irq_wake`, `irq_svc` pulses high for one cycle, exactly one cycle after `sys_clk_en` rises. After `wake_evt`, no pulse is raised. Wake inputs while running are ignored.
- R9: Priority when events coincide: power-on over external, external over watchdog, watchdog over a halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Power-on indication, active low, synchronous |
| ext_rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_to | input | 1 | Watchdog time-out pulse |
| halt_req | input | 1 | Core request to enter the halted state |
| wake_evt | input | 1 | Non-interrupt wake-up event |
| irq_wake | input | 1 | Interrupt wake-up request |
| sys_clk_en | output | 1 | System clock enable for the core |
| core_rst | output | 1 | Core reset; clears program counter and stack pointer |
| ready | output | 1 | Start-up wait complete |
| irq_svc | output | 1 | One-cycle pulse to begin interrupt service after a wake-up |
| flag_to | output | 1 | Time-out status flag |
| flag_pd | output | 1 | Power-down status flag |

## Verification
Three pairs of events can fall in the same cycle. First, an external reset and a watchdog time-out: the bench drives the pin low while halted, then times the watchdog pulse to reach the edge where the synchronised pin takes effect. The result is judged by the flags, which must follow the external rule (TO=0, PD=1) and not the watchdog rule. Second, a halt request and a watchdog pulse driven together while running: the watchdog rule must win, so the core goes into reset with TO set and never halts. Third, a second watchdog pulse placed in the middle of a start-up wait: it must push `ready` exactly 1024 cycles past the second pulse.

// File: rtl/pwrseq_pkg.sv
// Package: shared types of the reset and low-power controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pwrseq_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HALT  = 2'd1,
        ST_START = 2'd2
    } seq_state_t;
endpackage

// File: rtl/ext_rst_sync.sv
// Module: ext_rst_sync
// Brings the asynchronous active-low reset pin into the clock domain through
// a chain of STAGES flops. It presents 'hit' as an active-high, synchronous
// reset request. Assumes STAGES >= 2. Power-on fills the chain with ones,
// so no request is seen until the pin is actually driven low.
module ext_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic hit
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw pin.
                always_ff @(posedge clk) begin
                    if (!por_n) chain[0] <= 1'b1;
                    else        chain[0] <= pin_n;
                end
            end else begin : g_next
                // Later stages: shift the sampled level along.
                always_ff @(posedge clk) begin
                    if (!por_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign hit = ~chain[STAGES-1];
endmodule

// File: rtl/startup_timer.sv
// Module: startup_timer
// Counts the start-up wait. 'clear' restarts the count at zero. While 'run'
// is high the count advances once per cycle. 'done' is high in the last
// cycle of a wait of DELAY cycles. Assumes DELAY >= 2.
module startup_timer #(
    parameter int DELAY = 1024
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CNT_W = $clog2(DELAY) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && !clear && (cnt == LAST);

    // Count the wait; restart on clear, hold once finished.
    always_ff @(posedge clk) begin
        if (!por_n)                cnt <= '0;
        else if (clear)            cnt <= '0;
        else if (run && !done)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/flag_unit.sv
// Module: flag_unit
// Holds the TO and PD status flags. Power-on clears both. An external reset
// and a watchdog time-out each update them by their own rule, chosen by
// whether the core is halted. An accepted halt sets PD and clears TO.
// Assumes the caller has already applied priority to halt_take. Inside this
// unit, an external reset takes precedence over a watchdog time-out.
module flag_unit (
    input  logic clk,
    input  logic por_n,
    input  logic ext_hit,
    input  logic wdt_hit,
    input  logic halt_take,
    input  logic halted,
    output logic flag_to,
    output logic flag_pd
);
    // Apply the source- and state-dependent flag rule.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            flag_to <= 1'b0;
            flag_pd <= 1'b0;
        end else if (ext_hit) begin
            if (halted) begin
                flag_to <= 1'b0;
                flag_pd <= 1'b1;
            end
        end else if (wdt_hit) begin
            flag_to <= 1'b1;
            if (halted) flag_pd <= 1'b1;
        end else if (halt_take) begin
            flag_to <= 1'b0;
            flag_pd <= 1'b1;
        end
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
// Module: pwr_seq_ctrl (top)
// Runs the core through three states: running, halted and the start-up
// wait. It merges power-on, external-pin and watchdog resets into one core
// reset. It gates the system clock and raises a late interrupt-service pulse
// after an interrupt wake-up. Assumes clk is the free-running oscillator
// clock and por_n is synchronous to it.
module pwr_seq_ctrl #(
    parameter int DELAY       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic ext_rst_pin_n,
    input  logic wdt_to,
    input  logic halt_req,
    input  logic wake_evt,
    input  logic irq_wake,
    output logic sys_clk_en,
    output logic core_rst,
    output logic ready,
    output logic irq_svc,
    output logic flag_to,
    output logic flag_pd
);
    import pwrseq_pkg::*;

    seq_state_t state;
    logic       by_reset;
    logic       irq_pend;
    logic       ext_hit;
    logic       rst_evt;
    logic       halt_take;
    logic       wake_take;
    logic       wait_done;

    ext_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .pin_n (ext_rst_pin_n),
        .hit   (ext_hit)
    );

    assign rst_evt   = ext_hit | wdt_to;
    assign halt_take = (state == ST_RUN)  && halt_req && !rst_evt;
    assign wake_take = (state == ST_HALT) && (wake_evt || irq_wake) && !rst_evt;

    startup_timer #(.DELAY(DELAY)) u_timer (
        .clk   (clk),
        .por_n (por_n),
        .clear (rst_evt | wake_take),
        .run   (state == ST_START),
        .done  (wait_done)
    );

    flag_unit u_flags (
        .clk       (clk),
        .por_n     (por_n),
        .ext_hit   (ext_hit),
        .wdt_hit   (wdt_to),
        .halt_take (halt_take),
        .halted    (state == ST_HALT),
        .flag_to   (flag_to),
        .flag_pd   (flag_pd)
    );

    // Sequence run, halt and start-up; resets override every state.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state    <= ST_START;
            by_reset <= 1'b1;
            irq_pend <= 1'b0;
            irq_svc  <= 1'b0;
        end else begin
            irq_svc <= 1'b0;
            if (rst_evt) begin
                state    <= ST_START;
                by_reset <= 1'b1;
                irq_pend <= 1'b0;
            end else begin
                case (state)
                    ST_RUN: begin
                        if (irq_pend) begin
                            irq_svc  <= 1'b1;
                            irq_pend <= 1'b0;
                        end
                        if (halt_take) state <= ST_HALT;
                    end
                    ST_HALT: begin
                        if (wake_take) begin
                            state    <= ST_START;
                            by_reset <= 1'b0;
                            irq_pend <= irq_wake;
                        end
                    end
                    default: begin
                        if (wait_done) begin
                            state    <= ST_RUN;
                            by_reset <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    assign sys_clk_en = (state == ST_RUN);
    assign ready      = (state != ST_START);
    assign core_rst   = (state == ST_START) && by_reset;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
// Module: pwr_seq_ctrl_chk
// Property checker for pwr_seq_ctrl, attached with bind below.
// Assumes it sees the synchronised external reset request of the top.
module pwr_seq_ctrl_chk (
    input logic clk,
    input logic por_n,
    input logic ext_hit,
    input logic wdt_to,
    input logic halt_req,
    input logic sys_clk_en,
    input logic core_rst,
    input logic ready,
    input logic irq_svc,
    input logic flag_to,
    input logic flag_pd
);
    a_r2_reset_holds_core: assert property (@(posedge clk) disable iff (!por_n)
        (ext_hit || wdt_to) |=> (core_rst && !ready));

    a_r3_clock_only_when_ready: assert property (@(posedge clk) disable iff (!por_n)
        sys_clk_en |-> (ready && !core_rst));

    a_r5_halt_sets_pd: assert property (@(posedge clk) disable iff (!por_n)
        (sys_clk_en && halt_req && !ext_hit && !wdt_to) |=> (flag_pd && !flag_to && !sys_clk_en));

    a_r6_ext_running_keeps_flags: assert property (@(posedge clk) disable iff (!por_n)
        (ext_hit && sys_clk_en) |=> (flag_to == $past(flag_to) && flag_pd == $past(flag_pd)));

    a_r7_wdt_sets_to: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_to && !ext_hit) |=> flag_to);

    a_r8_irq_after_clock: assert property (@(posedge clk) disable iff (!por_n)
        irq_svc |-> (sys_clk_en && $past(sys_clk_en)));

    a_r8_irq_single: assert property (@(posedge clk) disable iff (!por_n)
        irq_svc |=> !irq_svc);
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .ext_hit    (ext_hit),
    .wdt_to     (wdt_to),
    .halt_req   (halt_req),
    .sys_clk_en (sys_clk_en),
    .core_rst   (core_rst),
    .ready      (ready),
    .irq_svc    (irq_svc),
    .flag_to    (flag_to),
    .flag_pd    (flag_pd)
);

// File: tb/pwr_seq_ctrl_test.sv
// Bench: scoreboard. The driver pushes the expected output vector after each
// edge it cares about. The monitor pops at the following falling edge and
// compares. Vector order: {core_rst, ready, sys_clk_en, irq_svc, flag_to, flag_pd}.
module pwr_seq_ctrl_test;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_rst_pin_n = 1'b1;
    logic wdt_to = 1'b0;
    logic halt_req = 1'b0;
    logic wake_evt = 1'b0;
    logic irq_wake = 1'b0;
    logic sys_clk_en, core_rst, ready, irq_svc, flag_to, flag_pd;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;

    always #5 clk = ~clk;

    pwr_seq_ctrl uut (
        .clk(clk), .por_n(por_n), .ext_rst_pin_n(ext_rst_pin_n), .wdt_to(wdt_to),
        .halt_req(halt_req), .wake_evt(wake_evt), .irq_wake(irq_wake),
        .sys_clk_en(sys_clk_en), .core_rst(core_rst), .ready(ready),
        .irq_svc(irq_svc), .flag_to(flag_to), .flag_pd(flag_pd)
    );

    // Wait n rising edges, then step just past the last one.
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Push one expected vector for the current cycle.
    task automatic expect_v(input logic [5:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare every queued vector at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [5:0] act;
            it  = q.pop_front();
            act = {core_rst, ready, sys_clk_en, irq_svc, flag_to, flag_pd};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    // Pulse one input for a single edge.
    task automatic pulse_wdt();
        wdt_to = 1'b1; tick(1); wdt_to = 1'b0;
    endtask

    initial begin
        // R1: power-on state.
        tick(3);
        expect_v(6'b100000, "R1 during por");
        por_n = 1'b1;
        tick(1);
        expect_v(6'b100000, "R1 first cycle after por");
        // R3: 1024-cycle wait from release (1 edge already spent).
        tick(1022);
        expect_v(6'b100000, "R3 still waiting at 1023");
        tick(1);
        expect_v(6'b011000, "R3 running at 1024");

        // R7: watchdog while running: TO=1, PD unchanged (0).
        pulse_wdt();
        expect_v(6'b100010, "R7 wdt while running");
        // R4: second watchdog mid-wait restarts the count.
        tick(500);
        pulse_wdt();
        expect_v(6'b100010, "R4 second wdt");
        tick(1023);
        expect_v(6'b100010, "R4 not ready before restarted count ends");
        tick(1);
        expect_v(6'b011010, "R4 ready after restarted count");

        // R2/R6: external reset while running, two-flop latency.
        ext_rst_pin_n = 1'b0;
        tick(2);
        expect_v(6'b011010, "R2 pin not yet through synchroniser");
        tick(1);
        expect_v(6'b100010, "R6 ext while running keeps flags");
        tick(10);
        expect_v(6'b100010, "R2 held while pin low");
        ext_rst_pin_n = 1'b1;
        tick(1025);
        expect_v(6'b100010, "R2 still in wait after pin release");
        tick(1);
        expect_v(6'b011010, "R3 ready after ext release");

        // R5: halt.
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        expect_v(6'b010001, "R5 halted flags and clock");
        // R8: wake while halted via plain event.
        wake_evt = 1'b1; tick(1); wake_evt = 1'b0;
        expect_v(6'b000001, "R8 plain wake wait");
        tick(1023);
        expect_v(6'b000001, "R8 plain wake still waiting");
        tick(1);
        expect_v(6'b011001, "R8 plain wake resumes");
        tick(1);
        expect_v(6'b011001, "R8 plain wake no service pulse");

        // R8: interrupt wake.
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        irq_wake = 1'b1; tick(1); irq_wake = 1'b0;
        tick(1023);
        expect_v(6'b000001, "R8 irq wake waiting");
        tick(1);
        expect_v(6'b011001, "R8 irq wake clock back, no pulse yet");
        tick(1);
        expect_v(6'b011101, "R8 irq service pulse one cycle late");
        tick(1);
        expect_v(6'b011001, "R8 irq service pulse single");

        // R8: wake inputs while running are ignored.
        wake_evt = 1'b1; irq_wake = 1'b1; tick(1); wake_evt = 1'b0; irq_wake = 1'b0;
        expect_v(6'b011001, "R8 wake while running ignored");
        tick(1026);
        expect_v(6'b011001, "R8 no late pulse after ignored wake");

        // R9/R6: ext and wdt in the same edge while halted -> ext rule.
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        expect_v(6'b010001, "R5 halted again");
        ext_rst_pin_n = 1'b0;
        tick(2);
        wdt_to = 1'b1; tick(1); wdt_to = 1'b0;
        expect_v(6'b100001, "R9 ext beats wdt while halted");
        ext_rst_pin_n = 1'b1;
        tick(1026);
        expect_v(6'b011001, "R6 ready after ext halted reset");

        // R7: watchdog while halted.
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        pulse_wdt();
        expect_v(6'b100011, "R7 wdt while halted");
        tick(1024);
        expect_v(6'b011011, "R3 ready after wdt halted");

        // R9: halt and wdt together while running -> wdt wins.
        halt_req = 1'b1; wdt_to = 1'b1; tick(1); halt_req = 1'b0; wdt_to = 1'b0;
        expect_v(6'b100011, "R9 wdt beats halt");
        // R5: halt during the wait is ignored.
        tick(10);
        halt_req = 1'b1; tick(1); halt_req = 1'b0;
        expect_v(6'b100011, "R5 halt in wait ignored");
        tick(1012);
        expect_v(6'b100011, "R5 still waiting");
        tick(1);
        expect_v(6'b011011, "R5 resumes running, not halted");

        tick(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule